// File: doc/BRIEF.md
# Sliced Run-Length Sample Stream Decoder

This block rebuilds logic-analyzer samples from a packed capture-memory readout. The readout arrives as 32-bit words in groups of nine. The first eight words hold the low 32 bits of eight 36-bit device words. The ninth word holds the top four bits of all eight. The block buffers a group, rebuilds each 36-bit device word, and feeds the words through a two-state run-length decoder. The output is a valid/ready stream with one 34-channel sample per beat. Each sample is repeated as many times as its run count asks.

A start pulse arms a transfer. It loads the number of valid device words and a sample limit. The input is always a whole number of nine-word groups. Device words past the valid count are padding: the block takes them in but draws nothing from them. Output stops once the limit is reached, even in the middle of a run or before the input is used up. The block then raises done and holds it until the next start.

Top module: `rleStreamDecoder`

## Requirements
- R1: After reset and before the first start, inReady, outValid and done are all 0.
- R2: A start pulse puts the decoder in the data state, zeroes the pending run and the emitted-sample count, and latches wordCount and sampleLimit. inReady is 1 in the cycle after the start when both values are non-zero. A start given during a run drops that run.
- R3: Input words are taken in groups of nine, with number 0 first. Word k (0..7) supplies bits 31:0 of device word k. Word 8 supplies bits 35:32 of device word k from its bits (31-4k) down to (28-4k).
- R4: In the data state, bits 33:0 of a device word are the sample and the run is 1 plus bit 34. When bit 35 is 0, the sample goes out on exactly that many consecutive output beats.
- R5: A device word with bit 35 set in the data state moves the decoder to the length state. The next valid device word, all 36 bits of it, is shifted left by one and added to the pending run. The decoder then returns to the data state and emits the run.
- R6: outData is 40 bits wide (5 bytes). Bits 33:0 hold the sample and bits 39:34 are 0. Byte k is outData[8k+7:8k], so byte 0 is the least significant.
- R7: While outValid is 1 and outReady is 0, outValid stays 1 and outData stays unchanged. inReady and outValid are never 1 together.
- R8: No output beat is offered once sampleLimit samples have been emitted. The block then raises done without taking further input. A limit of 0 gives done with no output.
- R9: The block accepts exactly ceil(wordCount/8) groups of nine words. Device words with index at or above wordCount produce no samples and leave the decoder state unchanged. A wordCount of 0 gives done with no input taken.
- R10: When the last group has been taken and the last run has been fully emitted, done rises. A pending run whose length word never arrives within the valid count is dropped.
- R11: done stays 1 until the next start. While done is 1, inReady and outValid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms a new transfer and latches the configuration |
| wordCount | input | CNT_W | Number of valid device words in the transfer |
| sampleLimit | input | LIMIT_W | Maximum number of samples to emit |
| inData | input | 32 | Input stream word |
| inValid | input | 1 | inData carries a word |
| inReady | output | 1 | Block accepts a word this cycle |
| outData | output | 40 | Five-byte sample, least significant byte first |
| outValid | output | 1 | outData carries a sample |
| outReady | input | 1 | Sink accepts the sample this cycle |
| done | output | 1 | Transfer complete or sample limit reached |

## Verification
The bench builds the block with CNT_W=8 and LIMIT_W=16. This keeps transfers short enough to sweep every valid word count from 0 to 24, which covers every padding remainder modulo eight, as well as full, partial and empty groups. A fixed sixteen-word stream is then replayed under every sample limit from 0 to 20, which places the cut-off before, inside and after individual runs. Random stalls on both handshakes, a length word that uses only the rebuilt top nibble, a dangling length flag and a restart during a long run each reach one corner of the decoder.

// File: rtl/rleDecPkg.sv
package rleDecPkg;
  localparam int LOW_W    = 32;
  localparam int NIB_W    = 4;
  localparam int SLICE_N  = 8;
  localparam int SLOT_N   = SLICE_N + 1;
  localparam int DEV_W    = LOW_W + NIB_W;
  localparam int CHAN_W   = DEV_W - 2;
  localparam int RUN_BIT  = CHAN_W;
  localparam int FLAG_BIT = CHAN_W + 1;
  localparam int OUT_W    = 40;
  localparam int RUN_W    = DEV_W + 2;
  localparam int IDX_W    = $clog2(SLICE_N);
  localparam int SLOT_W   = $clog2(SLOT_N);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_DRAIN, ST_DONE} phase_t;
  typedef enum logic {RLE_DATA, RLE_LEN} rle_t;

  typedef struct packed {
    logic              clear;
    logic              capture;
    logic [SLOT_W-1:0] slot;
    logic              decode;
    logic [IDX_W-1:0]  idx;
    logic              pad;
    logic              emit;
  } strobe_t;
endpackage

// File: rtl/rleDecCtrl.sv
module rleDecCtrl
  import rleDecPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int LIMIT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CNT_W-1:0]   wordCount,
  input  logic [LIMIT_W-1:0] sampleLimit,
  input  logic               inValid,
  input  logic               outReady,
  input  logic               runPending,
  output logic               inReady,
  output logic               outValid,
  output logic               done,
  output strobe_t            stb
);
  localparam int IDXSUM_W = CNT_W + IDX_W + 1;

  phase_t             phase;
  logic [SLOT_W-1:0]  slot;
  logic [SLOT_W-1:0]  dIdx;
  logic [CNT_W-1:0]   sliceCnt;
  logic [CNT_W-1:0]   wordsReg;
  logic [LIMIT_W-1:0] limitReg;
  logic [LIMIT_W-1:0] sampleCnt;

  logic [CNT_W:0]     sliceTotal;
  logic [IDXSUM_W-1:0] devIdx;
  logic limitHit, noSlices, lastSlice, padWord;
  logic inFire, outFire, decodeW, sliceEnd;

  assign sliceTotal = ({1'b0, wordsReg} + (CNT_W + 1)'(SLICE_N - 1)) >> IDX_W;
  assign devIdx     = {1'b0, sliceCnt, {IDX_W{1'b0}}} + IDXSUM_W'(dIdx);
  assign padWord    = devIdx >= IDXSUM_W'(wordsReg);
  assign limitHit   = sampleCnt >= limitReg;
  assign noSlices   = sliceTotal == '0;
  assign lastSlice  = ({1'b0, sliceCnt} + 1'b1) == sliceTotal;

  assign inReady  = (phase == ST_FILL) && !limitHit && !noSlices;
  assign inFire   = inReady && inValid;
  assign outValid = (phase == ST_DRAIN) && runPending && !limitHit;
  assign outFire  = outValid && outReady;
  assign decodeW  = (phase == ST_DRAIN) && !runPending && !limitHit
                    && (dIdx < SLOT_W'(SLICE_N));
  assign sliceEnd = (phase == ST_DRAIN) && !runPending && !limitHit
                    && (dIdx == SLOT_W'(SLICE_N));
  assign done     = phase == ST_DONE;

  always_comb begin
    stb         = '0;
    stb.clear   = start;
    stb.capture = inFire;
    stb.slot    = slot;
    stb.decode  = decodeW;
    stb.idx     = dIdx[IDX_W-1:0];
    stb.pad     = padWord;
    stb.emit    = outFire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= ST_IDLE;
      slot      <= '0;
      dIdx      <= '0;
      sliceCnt  <= '0;
      wordsReg  <= '0;
      limitReg  <= '0;
      sampleCnt <= '0;
    end else if (start) begin
      phase     <= ST_FILL;
      slot      <= '0;
      dIdx      <= '0;
      sliceCnt  <= '0;
      sampleCnt <= '0;
      wordsReg  <= wordCount;
      limitReg  <= sampleLimit;
    end else begin
      if (outFire) sampleCnt <= sampleCnt + 1'b1;
      case (phase)
        ST_FILL: begin
          if (limitHit || noSlices) begin
            phase <= ST_DONE;
          end else if (inFire) begin
            if (slot == SLOT_W'(SLICE_N)) begin
              slot  <= '0;
              dIdx  <= '0;
              phase <= ST_DRAIN;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (limitHit) begin
            phase <= ST_DONE;
          end else if (decodeW) begin
            dIdx <= dIdx + 1'b1;
          end else if (sliceEnd) begin
            sliceCnt <= sliceCnt + 1'b1;
            phase    <= lastSlice ? ST_DONE : ST_FILL;
          end
        end
        default: ;
      endcase
    end
  end

  a_r8_limit_bound: assert property (@(posedge clk) disable iff (!rstN)
    (phase != ST_IDLE) |-> (sampleCnt <= limitReg));

  a_r11_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  a_r7_one_side: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  a_r3_slot_range: assert property (@(posedge clk) disable iff (!rstN)
    inFire |-> (slot <= SLOT_W'(SLICE_N)));
endmodule

// File: rtl/rleDecPath.sv
module rleDecPath
  import rleDecPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [LOW_W-1:0] inData,
  output logic [OUT_W-1:0] outData,
  output logic             runPending
);
  logic [SLICE_N-1:0][LOW_W-1:0] lowBuf;
  logic [LOW_W-1:0]              nibWord;
  logic [SLICE_N-1:0][DEV_W-1:0] rebuilt;
  logic [DEV_W-1:0]              word;
  logic [CHAN_W-1:0]             curSample;
  logic [RUN_W-1:0]              runLeft;
  rle_t                          rle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowBuf  <= '0;
      nibWord <= '0;
    end else if (stb.capture) begin
      for (int k = 0; k < SLICE_N; k++) begin
        if (stb.slot == SLOT_W'(k)) lowBuf[k] <= inData;
      end
      if (stb.slot == SLOT_W'(SLICE_N)) nibWord <= inData;
    end
  end

  for (genvar g = 0; g < SLICE_N; g++) begin : gRebuild
    assign rebuilt[g] = {nibWord[LOW_W-1-NIB_W*g -: NIB_W], lowBuf[g]};
  end

  assign word = rebuilt[stb.idx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rle       <= RLE_DATA;
      runLeft   <= '0;
      curSample <= '0;
    end else if (stb.clear) begin
      rle     <= RLE_DATA;
      runLeft <= '0;
    end else if (stb.decode && !stb.pad) begin
      if (rle == RLE_DATA) begin
        curSample <= word[CHAN_W-1:0];
        runLeft   <= RUN_W'(word[RUN_BIT]) + RUN_W'(1);
        rle       <= word[FLAG_BIT] ? RLE_LEN : RLE_DATA;
      end else begin
        runLeft <= runLeft + {1'b0, word, 1'b0};
        rle     <= RLE_DATA;
      end
    end else if (stb.emit) begin
      runLeft <= runLeft - 1'b1;
    end
  end

  assign runPending = (rle == RLE_DATA) && (runLeft != '0);
  assign outData    = {{(OUT_W - CHAN_W){1'b0}}, curSample};

  a_r5_len_returns: assert property (@(posedge clk) disable iff (!rstN)
    (stb.decode && !stb.pad && !stb.clear && rle == RLE_LEN) |=> (rle == RLE_DATA));

  a_r9_pad_silent: assert property (@(posedge clk) disable iff (!rstN)
    (stb.decode && stb.pad && !stb.clear) |=> ($stable(runLeft) && $stable(rle) && $stable(curSample)));

  a_r4_emit_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emit && !stb.clear) |=> (runLeft == $past(runLeft) - 1'b1));

  a_r4_no_emit_idle: assert property (@(posedge clk) disable iff (!rstN)
    stb.emit |-> runPending);
endmodule

// File: rtl/rleStreamDecoder.sv
module rleStreamDecoder
  import rleDecPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int LIMIT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CNT_W-1:0]   wordCount,
  input  logic [LIMIT_W-1:0] sampleLimit,
  input  logic [LOW_W-1:0]   inData,
  input  logic               inValid,
  output logic               inReady,
  output logic [OUT_W-1:0]   outData,
  output logic               outValid,
  input  logic               outReady,
  output logic               done
);
  strobe_t stb;
  logic    runPending;

  rleDecCtrl #(.CNT_W(CNT_W), .LIMIT_W(LIMIT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .wordCount(wordCount),
    .sampleLimit(sampleLimit), .inValid(inValid), .outReady(outReady),
    .runPending(runPending), .inReady(inReady), .outValid(outValid),
    .done(done), .stb(stb)
  );

  rleDecPath uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .outData(outData), .runPending(runPending)
  );

  a_r7_hold_beat: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !start) |=> (outValid && $stable(outData)));

  a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!inReady && !outValid));

  a_r6_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData[OUT_W-1:CHAN_W] == '0));
endmodule

// File: tb/tb_rleStreamDecoder.sv
`timescale 1ns/1ps
module tb_rleStreamDecoder;
  localparam int CNT_W = 8;
  localparam int LIMIT_W = 16;
  localparam int MAXO = 1024;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [CNT_W-1:0] wordCount = '0;
  logic [LIMIT_W-1:0] sampleLimit = '0;
  logic [31:0] inData = '0;
  logic inValid = 1'b0, inReady;
  logic [39:0] outData;
  logic outValid, outReady = 1'b0, done;

  always #2 clk = ~clk;

  rleStreamDecoder #(.CNT_W(CNT_W), .LIMIT_W(LIMIT_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .wordCount(wordCount),
    .sampleLimit(sampleLimit), .inData(inData), .inValid(inValid),
    .inReady(inReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .done(done)
  );

  int checks = 0, failures = 0;
  logic [35:0] dev [0:255];
  logic [31:0] stream [0:299];
  logic [39:0] expS [0:MAXO-1];
  logic [39:0] got [0:MAXO-1];
  int expN, gotN;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic genWords(input int n);
    bit inLen = 0;
    for (int k = 0; k < 256; k++) begin
      if (k < n) begin
        if (inLen) begin
          dev[k] = 36'($urandom % 6);
          inLen = 0;
        end else begin
          dev[k] = {($urandom % 4) == 0, 1'($urandom), 2'($urandom), 32'($urandom)};
          inLen = dev[k][35];
        end
      end else begin
        dev[k] = {4'($urandom), 32'($urandom)};
      end
    end
  endtask

  task automatic pushRun(input logic [33:0] s, input longint run, input int lim);
    for (longint r = 0; r < run && expN < lim && expN < MAXO; r++) begin
      expS[expN] = {6'b0, s};
      expN++;
    end
  endtask

  task automatic buildExpect(input int n, input int lim);
    bit st = 0;
    longint run = 0;
    logic [33:0] samp = '0;
    expN = 0;
    for (int k = 0; k < n; k++) begin
      if (!st) begin
        samp = dev[k][33:0];
        run = 1 + longint'(dev[k][34]);
        if (dev[k][35]) st = 1;
        else pushRun(samp, run, lim);
      end else begin
        run = run + (longint'(dev[k]) << 1);
        st = 0;
        pushRun(samp, run, lim);
      end
    end
  endtask

  task automatic runCase(input int n, input int lim, input int abortAt, input string tag);
    int slices = (n + 7) / 8;
    int nIn = slices * 9;
    int ptr = 0, viol = 0, cyc = 0, mism = 0, firstBad = -1;
    bit ov, ir, dn, rdy, iv, prevStall = 0;
    logic [39:0] od, prevData = '0;
    for (int s = 0; s < slices; s++) begin
      logic [31:0] nib = '0;
      for (int i = 0; i < 8; i++) begin
        stream[s*9+i] = dev[s*8+i][31:0];
        nib = nib | (32'(dev[s*8+i][35:32]) << (28 - 4*i));
      end
      stream[s*9+8] = nib;
    end
    if (abortAt < 0) buildExpect(n, lim);
    gotN = 0;
    @(negedge clk);
    start = 1'b1; wordCount = CNT_W'(n); sampleLimit = LIMIT_W'(lim);
    @(negedge clk);
    start = 1'b0;
    if (n > 0 && lim > 0 && abortAt < 0)
      check(inReady == 1'b1, "R2", {tag, " inReady after start"}, longint'(inReady), 1);
    while (cyc < 20000) begin
      ov = outValid; od = outData; ir = inReady; dn = done;
      if (ir && ov) viol++;
      if (dn && (ir || ov)) viol++;
      if (prevStall && (!ov || od != prevData)) viol++;
      if (dn) break;
      rdy = ($urandom % 4) != 0;
      iv = (ptr < nIn) && (($urandom % 5) != 0);
      outReady = rdy;
      inValid = iv;
      inData = (ptr < nIn) ? stream[ptr] : 32'hDEAD_BEEF;
      if (ov && rdy) begin
        if (gotN < MAXO) got[gotN] = od;
        gotN++;
      end
      if (iv && ir) ptr++;
      prevStall = ov && !rdy;
      prevData = od;
      cyc++;
      if (abortAt >= 0 && gotN >= abortAt) break;
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b0;
    if (abortAt >= 0) return;
    check(dn == 1'b1, "R10", {tag, " done reached"}, longint'(dn), 1);
    check(gotN == expN, "R4", {tag, " sample count"}, gotN, expN);
    for (int j = 0; j < gotN && j < expN && j < MAXO; j++)
      if (got[j] !== expS[j]) begin
        mism++;
        if (firstBad < 0) firstBad = j;
      end
    if (firstBad >= 0)
      check(0, "R3 R5 R6", {tag, " sample value"}, longint'(got[firstBad]), longint'(expS[firstBad]));
    else
      check(1, "R3 R5 R6", {tag, " sample values"}, 0, 0);
    check(viol == 0, "R7 R11", {tag, " handshake rules"}, viol, 0);
    if (expN < lim) check(ptr == nIn, "R9", {tag, " words taken"}, ptr, nIn);
    else check(ptr <= nIn, "R8", {tag, " words taken"}, ptr, nIn);
    repeat (3) @(negedge clk);
    check(done == 1'b1 && outValid == 1'b0 && inReady == 1'b0, "R11",
          {tag, " done held"}, longint'({done, outValid, inReady}), 4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(inReady == 0 && outValid == 0 && done == 0, "R1", "idle after reset",
          longint'({inReady, outValid, done}), 0);

    // R6: byte order on a hand-built word with no flags
    for (int k = 0; k < 8; k++) dev[k] = {2'b00, 34'h3_0102_0304 + 34'(k)};
    runCase(1, 16'hFFFF, -1, "R6 single");
    check(got[0][7:0] == 8'h04 && got[0][39:34] == 6'd0, "R6", "low byte first",
          longint'(got[0]), 40'h03_0102_0304);

    // R3 R4 R5 R9: sweep word counts across padding remainders
    for (int n = 0; n <= 24; n++) begin
      genWords(n);
      runCase(n, 16'hFFFF, -1, $sformatf("R9 sweep n=%0d", n));
    end

    // R8: limit sweep over one fixed stream
    genWords(16);
    for (int lim = 0; lim <= 20; lim++)
      runCase(16, lim, -1, $sformatf("R8 limit=%0d", lim));

    // R5 R8: length word carried only in the rebuilt top nibble
    genWords(8);
    dev[0] = {1'b1, 1'b0, 34'h2_AAAA_5555};
    dev[1] = 36'h1_0000_0000;
    runCase(8, 10, -1, "R5 nibble length");

    // R10: dangling length flag on the last valid word
    genWords(5);
    dev[3][35] = 1'b0;
    dev[4] = {1'b1, 1'b1, 34'h1_2345_6789};
    runCase(5, 16'hFFFF, -1, "R10 dangling flag");

    // R2: restart during a long run, then a clean transfer
    genWords(2);
    dev[0] = {1'b1, 1'b0, 34'h0_0F0F_0F0F};
    dev[1] = 36'd100;
    runCase(2, 16'hFFFF, 5, "R2 abort");
    genWords(11);
    runCase(11, 16'hFFFF, -1, "R2 after restart");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule